// File: doc/BRIEF.md
# Complementary PWM Pair with Dead Band

This block drives one high-side and one low-side gate signal from a single time base. The time base either counts up and wraps (edge-aligned) or counts up and back down (center-aligned). A compare against the duty value sets the raw high-side level. A dead-band stage then holds both gates low for a programmed number of cycles whenever the raw level flips, so the two switches never conduct together.

Period, duty, edge dead band, center dead band and alignment each have a data input and a write strobe. A written value first lands in a shadow copy. All shadow copies move to the working copies together at the period boundary, and that boundary is also driven out as a one-cycle pulse. When the immediate-update control is set, a write goes straight into the working copy instead. The duty endpoints give a gate that is fully off or fully on, with no dead-band notch, even when the dead band is not zero.

Top module: `cpwm_pair`

## Requirements
- R1: Edge-aligned (alignment value 0): the counter runs 0,1,…,P and then returns to 0, so a period lasts P+1 cycles. The boundary output is high in the cycle where the counter equals P. When P is 0, the boundary output is high on every cycle.
- R2: Center-aligned (alignment value 1, P ≥ 1): the counter runs up from 0 to P and then down to 1, so a period lasts 2·P cycles. The boundary output is high in the last cycle of each period, which is the down-counting cycle at 1 (or the cycle at 1 when P is 1).
- R3: With immediate update off, written values are held in shadow copies. The working period, duty, both dead bands and the alignment all change only at the clock edge that ends a boundary cycle, and they all change together. A write strobed in the boundary cycle itself is included in that transfer.
- R4: With immediate update on, a strobed value becomes the working value at the next clock edge, whatever the counter position.
- R5: Edge-aligned: the raw high-side level is counter < D. D = 0 keeps H low and L high for the whole period. D = P+1 keeps H high and L low for the whole period.
- R6: Center-aligned: the raw high-side level is counter+1 < D. D = P+2 keeps H high and L low for the whole period.
- R7: After every flip of the raw level, both outputs stay low for K cycles, and then the new side rises. K is the edge dead band in edge-aligned mode and half (rounded down) of the center dead band in center-aligned mode. This applies even when the flip comes from an immediate duty write. The outputs follow the compare with one register of latency.
- R8: Center-aligned: a non-zero duty smaller than half the center dead band is raised to that half before the compare.
- R9: When the effective duty is 0 or at or above the full value (P+1 edge-aligned, P+2 center-aligned), no dead band is inserted. Any running dead band is cancelled.
- R10: H and L are never high in the same cycle.
- R11: While reset is asserted, both outputs are low and every working value is 0, so the boundary output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_we | input | 1 | Period write strobe |
| per_d | input | CW | Period value P |
| duty_we | input | 1 | Duty write strobe |
| duty_d | input | CW | Duty value D |
| dt_we | input | 1 | Edge dead-band write strobe |
| dt_d | input | DTW | Edge dead band in cycles |
| adt_we | input | 1 | Center dead-band write strobe |
| adt_d | input | DTW | Center dead band, halved before use |
| mode_we | input | 1 | Alignment write strobe |
| mode_d | input | 1 | 0 edge-aligned, 1 center-aligned |
| imm_we | input | 1 | Immediate-update control write strobe |
| imm_d | input | 1 | 1 selects immediate update |
| pwm_h | output | 1 | High-side gate |
| pwm_l | output | 1 | Low-side gate |
| pb | output | 1 | Period boundary pulse |

## Verification
Two things can fall in the same cycle here. One is a register write and the period-boundary transfer. The other is a raw-level flip and a dead band that is still counting down from the previous flip. The bench forces the first case by waiting for a cycle with the boundary high and strobing a duty write in it. It forces the second with short random duty and period values against long dead bands. In both cases a cycle model in the bench decides whether the write or the new flip must show up at the outputs, and every cycle of H, L and the boundary pulse is compared against that model.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    ALIGN_EDGE   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;
endpackage

// File: rtl/cpwm_buf.sv
// One buffered setting: a shadow copy that takes writes and a working copy
// loaded at the boundary or, under immediate update, straight from the write.
module cpwm_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  input  logic         imm,
  input  logic         pb,
  output logic [W-1:0] act
);
  logic [W-1:0] shd_q, shd_n;
  logic [W-1:0] act_q, act_n;

  always_comb begin
    shd_n = we ? d : shd_q;
    if (imm && we)
      act_n = d;
    else if (pb)
      act_n = shd_n;
    else
      act_n = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_n;
      act_q <= act_n;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per,
  input  align_e        align,
  output logic [CW-1:0] cnt,
  output logic          pb
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          dn_q, dn_n;
  logic          last;

  always_comb begin
    if (per == '0)
      last = 1'b1;
    else if (align == ALIGN_EDGE)
      last = (cnt_q >= per);
    else if (dn_q)
      last = (cnt_q <= CW'(1));
    else
      last = (cnt_q >= per) && (per == CW'(1));

    if (last) begin
      cnt_n = '0;
      dn_n  = 1'b0;
    end else if (align == ALIGN_EDGE) begin
      cnt_n = cnt_q + CW'(1);
      dn_n  = 1'b0;
    end else if (!dn_q && (cnt_q < per)) begin
      cnt_n = cnt_q + CW'(1);
      dn_n  = 1'b0;
    end else begin
      cnt_n = cnt_q - CW'(1);
      dn_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dn_q  <= dn_n;
    end
  end

  assign cnt = cnt_q;
  assign pb  = last;
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic [CW-1:0]  cnt,
  input  logic [CW-1:0]  per,
  input  logic [CW-1:0]  duty,
  input  logic [DTW-1:0] dt,
  input  logic [DTW-1:0] adt,
  input  align_e         align,
  output logic           raw_h,
  output logic           sat,
  output logic [DTW-1:0] dly
);
  localparam int XW = CW + 2;

  logic [XW-1:0] half, de, pos, full;

  always_comb begin
    half = XW'(adt >> 1);
    de   = XW'(duty);
    if ((align == ALIGN_CENTER) && (duty != '0) && (de < half))
      de = half;
    if (align == ALIGN_CENTER) begin
      pos  = XW'(cnt) + XW'(1);
      full = XW'(per) + XW'(2);
      dly  = adt >> 1;
    end else begin
      pos  = XW'(cnt);
      full = XW'(per) + XW'(1);
      dly  = dt;
    end
    raw_h = (pos < de);
    sat   = (de == '0) || (de >= full);
  end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw_h,
  input  logic           sat,
  input  logic [DTW-1:0] dly,
  output logic           pwm_h,
  output logic           pwm_l
);
  logic           rh_q;
  logic [DTW-1:0] dc_q, dc_n;
  logic           h_q, h_n, l_q, l_n;

  always_comb begin
    if (sat)
      dc_n = '0;
    else if (raw_h != rh_q)
      dc_n = dly;
    else if (dc_q != '0)
      dc_n = dc_q - DTW'(1);
    else
      dc_n = '0;
    h_n = raw_h && (dc_n == '0);
    l_n = !raw_h && (dc_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_q <= 1'b0;
      dc_q <= '0;
      h_q  <= 1'b0;
      l_q  <= 1'b0;
    end else begin
      rh_q <= raw_h;
      dc_q <= dc_n;
      h_q  <= h_n;
      l_q  <= l_n;
    end
  end

  assign pwm_h = h_q;
  assign pwm_l = l_q;
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           per_we,
  input  logic [CW-1:0]  per_d,
  input  logic           duty_we,
  input  logic [CW-1:0]  duty_d,
  input  logic           dt_we,
  input  logic [DTW-1:0] dt_d,
  input  logic           adt_we,
  input  logic [DTW-1:0] adt_d,
  input  logic           mode_we,
  input  logic           mode_d,
  input  logic           imm_we,
  input  logic           imm_d,
  output logic           pwm_h,
  output logic           pwm_l,
  output logic           pb
);
  localparam int NCW = 2;  // fields of counter width
  localparam int NDW = 2;  // fields of dead-band width

  logic          imm_q, imm_n;
  logic [CW-1:0] per_a, duty_a, cnt;
  logic [DTW-1:0] dt_a, adt_a;
  logic [0:0]    mode_raw;
  align_e        mode_a;
  logic          raw_h, sat;
  logic [DTW-1:0] dly;

  logic          cw_we [NCW];
  logic [CW-1:0] cw_d  [NCW];
  logic [CW-1:0] cw_a  [NCW];
  logic          dw_we [NDW];
  logic [DTW-1:0] dw_d [NDW];
  logic [DTW-1:0] dw_a [NDW];

  assign cw_we[0] = per_we;   assign cw_d[0] = per_d;
  assign cw_we[1] = duty_we;  assign cw_d[1] = duty_d;
  assign dw_we[0] = dt_we;    assign dw_d[0] = dt_d;
  assign dw_we[1] = adt_we;   assign dw_d[1] = adt_d;

  for (genvar i = 0; i < NCW; i++) begin : g_cw
    cpwm_buf #(.W(CW)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(cw_we[i]), .d(cw_d[i]),
      .imm(imm_q), .pb(pb), .act(cw_a[i])
    );
  end

  for (genvar i = 0; i < NDW; i++) begin : g_dw
    cpwm_buf #(.W(DTW)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(dw_we[i]), .d(dw_d[i]),
      .imm(imm_q), .pb(pb), .act(dw_a[i])
    );
  end

  cpwm_buf #(.W(1)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .d(mode_d),
    .imm(imm_q), .pb(pb), .act(mode_raw)
  );

  assign per_a  = cw_a[0];
  assign duty_a = cw_a[1];
  assign dt_a   = dw_a[0];
  assign adt_a  = dw_a[1];
  assign mode_a = align_e'(mode_raw[0]);

  always_comb imm_n = imm_we ? imm_d : imm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imm_q <= 1'b0;
    else        imm_q <= imm_n;
  end

  cpwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .per(per_a), .align(mode_a),
    .cnt(cnt), .pb(pb)
  );

  cpwm_compare #(.CW(CW), .DTW(DTW)) u_cmp (
    .cnt(cnt), .per(per_a), .duty(duty_a), .dt(dt_a), .adt(adt_a),
    .align(mode_a), .raw_h(raw_h), .sat(sat), .dly(dly)
  );

  cpwm_deadband #(.DTW(DTW)) u_db (
    .clk(clk), .rst_n(rst_n), .raw_h(raw_h), .sat(sat), .dly(dly),
    .pwm_h(pwm_h), .pwm_l(pwm_l)
  );
endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk #(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwm_h,
  input logic           pwm_l,
  input logic           pb,
  input logic           imm_q,
  input logic           per_we,
  input logic [CW-1:0]  per_d,
  input logic [CW-1:0]  per_a,
  input logic [CW-1:0]  duty_a,
  input logic [CW-1:0]  cnt,
  input logic [DTW-1:0] dt_a,
  input logic [DTW-1:0] adt_a,
  input logic           mode_a
);
  // R10
  gates_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_h && pwm_l));

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_q && !pb) |=> ($stable(per_a) && $stable(duty_a) && $stable(dt_a)
                         && $stable(adt_a) && $stable(mode_a)));

  // R4
  imm_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_q && per_we) |=> (per_a == $past(per_d)));

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb |=> (cnt == '0));

  // R2
  center_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a && !pb && $stable(per_a) && $stable(mode_a) && (per_a > 1))
      |-> (cnt <= per_a) || $past(cnt > per_a));
endmodule

bind cpwm_pair cpwm_pair_chk #(.CW(CW), .DTW(DTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_h(pwm_h), .pwm_l(pwm_l), .pb(pb),
  .imm_q(imm_q), .per_we(per_we), .per_d(per_d), .per_a(per_a),
  .duty_a(duty_a), .cnt(cnt), .dt_a(dt_a), .adt_a(adt_a),
  .mode_a(mode_raw[0])
);

// File: tb/tb_cpwm_pair.sv
`timescale 1ns/1ps
module tb_cpwm_pair;
  localparam int CW  = 16;
  localparam int DTW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic per_we, duty_we, dt_we, adt_we, mode_we, imm_we;
  logic [CW-1:0] per_d, duty_d;
  logic [DTW-1:0] dt_d, adt_d;
  logic mode_d, imm_d;
  logic pwm_h, pwm_l, pb;

  always #4 clk = ~clk;

  cpwm_pair #(.CW(CW), .DTW(DTW)) dut (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_d(per_d), .duty_we(duty_we), .duty_d(duty_d),
    .dt_we(dt_we), .dt_d(dt_d), .adt_we(adt_we), .adt_d(adt_d),
    .mode_we(mode_we), .mode_d(mode_d), .imm_we(imm_we), .imm_d(imm_d),
    .pwm_h(pwm_h), .pwm_l(pwm_l), .pb(pb)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  bit run_on = 0;
  string ph = "";

  // bench model state
  int s_per, s_duty, s_dt, s_adt, s_mode;
  int a_per, a_duty, a_dt, a_adt, a_mode;
  int m_imm, m_cnt, m_dn, m_rh, m_dc, m_h, m_l, m_sat;

  function automatic bit f_last(int per, int mode, int cnt, int dn);
    if (per == 0) return 1'b1;
    if (mode == 0) return cnt >= per;
    if (dn != 0) return cnt <= 1;
    return (cnt >= per) && (per == 1);
  endfunction

  function automatic int f_duty_eff(int duty, int adt, int mode);
    if (mode == 1 && duty != 0 && duty < adt / 2) return adt / 2;
    return duty;
  endfunction

  task automatic chk(string req, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s got %0d exp %0d at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_per = 0; s_duty = 0; s_dt = 0; s_adt = 0; s_mode = 0;
      a_per = 0; a_duty = 0; a_dt = 0; a_adt = 0; a_mode = 0;
      m_imm = 0; m_cnt = 0; m_dn = 0; m_rh = 0; m_dc = 0;
      m_h = 0; m_l = 0; m_sat = 0;
    end else begin
      bit last, raw, sat;
      int de, full, dly;
      last = f_last(a_per, a_mode, m_cnt, m_dn);
      de   = f_duty_eff(a_duty, a_adt, a_mode);
      if (a_mode == 1) begin
        raw = (m_cnt + 1) < de; full = a_per + 2; dly = a_adt / 2;
      end else begin
        raw = m_cnt < de; full = a_per + 1; dly = a_dt;
      end
      sat = (de == 0) || (de >= full);
      if (sat) m_dc = 0;
      else if (int'(raw) != m_rh) m_dc = dly;
      else if (m_dc > 0) m_dc = m_dc - 1;
      m_rh = raw; m_sat = sat;
      m_h = (raw && m_dc == 0) ? 1 : 0;
      m_l = (!raw && m_dc == 0) ? 1 : 0;
      if (last) begin m_cnt = 0; m_dn = 0; end
      else if (a_mode == 0) begin m_cnt++; m_dn = 0; end
      else if (m_dn == 0 && m_cnt < a_per) m_cnt++;
      else begin m_cnt--; m_dn = 1; end
      if (per_we)  s_per  = per_d;
      if (duty_we) s_duty = duty_d;
      if (dt_we)   s_dt   = dt_d;
      if (adt_we)  s_adt  = adt_d;
      if (mode_we) s_mode = mode_d;
      if (m_imm == 1 && per_we)  a_per  = per_d;  else if (last) a_per  = s_per;
      if (m_imm == 1 && duty_we) a_duty = duty_d; else if (last) a_duty = s_duty;
      if (m_imm == 1 && dt_we)   a_dt   = dt_d;   else if (last) a_dt   = s_dt;
      if (m_imm == 1 && adt_we)  a_adt  = adt_d;  else if (last) a_adt  = s_adt;
      if (m_imm == 1 && mode_we) a_mode = mode_d; else if (last) a_mode = s_mode;
      if (imm_we) m_imm = imm_d;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run_on && rst_n) begin
      string rq;
      chk((a_mode == 1) ? "R2" : "R1", pb, f_last(a_per, a_mode, m_cnt, m_dn));
      if (ph != "") rq = ph;
      else if (m_sat == 1) rq = "R9";
      else if (m_dc > 0) rq = "R7";
      else rq = (a_mode == 1) ? "R6" : "R5";
      chk(rq, pwm_h, m_h);
      chk(rq, pwm_l, m_l);
      chk("R10", (pwm_h && pwm_l) ? 1 : 0, 0);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      per_we = 0; duty_we = 0; dt_we = 0; adt_we = 0; mode_we = 0; imm_we = 0;
    end
  endtask

  task automatic set_all(int per, int duty, int dt, int adt, int mode);
    per_we = 1;  per_d  = CW'(per);
    duty_we = 1; duty_d = CW'(duty);
    dt_we = 1;   dt_d   = DTW'(dt);
    adt_we = 1;  adt_d  = DTW'(adt);
    mode_we = 1; mode_d = mode[0];
  endtask

  task automatic count_win(int n, output int hc, output int lc);
    hc = 0; lc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hc += int'(pwm_h);
      lc += int'(pwm_l);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog expired got 0 exp 1");
      summary();
      $finish;
    end
  end

  initial begin
    int hc, lc;
    void'($urandom(32'd24680));
    rst_n = 0;
    per_we = 0; duty_we = 0; dt_we = 0; adt_we = 0; mode_we = 0; imm_we = 0;
    per_d = '0; duty_d = '0; dt_d = '0; adt_d = '0; mode_d = 0; imm_d = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", pwm_h, 0);
    chk("R11", pwm_l, 0);
    chk("R11", pb, 1);
    rst_n = 1;
    run_on = 1;

    // edge-aligned mid duty with dead band
    set_all(9, 4, 2, 0, 0);
    tick(60);
    // R5: 0% and 100% endpoints, R9: no notch
    duty_we = 1; duty_d = 0; tick(25);
    count_win(20, hc, lc);
    chk("R5", hc, 0); chk("R5", lc, 20);
    duty_we = 1; duty_d = 10; tick(25);
    count_win(20, hc, lc);
    chk("R5", hc, 20); chk("R9", lc, 0);

    // center-aligned
    set_all(10, 5, 0, 6, 1);
    tick(80);
    // R6: full on at P+2
    duty_we = 1; duty_d = 12; tick(45);
    count_win(40, hc, lc);
    chk("R6", hc, 40); chk("R6", lc, 0);
    duty_we = 1; duty_d = 11; tick(60);
    // R8: clamp of small duty against half the center dead band
    ph = "R8";
    adt_we = 1; adt_d = 8; duty_we = 1; duty_d = 2; tick(45);
    count_win(40, hc, lc);
    chk("R8", hc, 2);
    ph = "";

    // R4: immediate updates, including a mid-period duty change
    ph = "R4";
    imm_we = 1; imm_d = 1; tick(2);
    set_all(15, 7, 1, 4, 0); tick(13);
    duty_we = 1; duty_d = 3; tick(20);
    duty_we = 1; duty_d = 12; tick(9);
    mode_we = 1; mode_d = 1; tick(40);
    imm_we = 1; imm_d = 0; tick(2);
    ph = "";

    // R3: write landing in the boundary cycle
    ph = "R3";
    for (int k = 0; k < 6; k++) begin
      while (pb !== 1'b1) @(negedge clk);
      duty_we = 1; duty_d = CW'(2 + 3 * k);
      if (k == 3) begin per_we = 1; per_d = 7; mode_we = 1; mode_d = 0; end
      tick(1);
      tick(3);
    end
    tick(20);
    ph = "";

    // constrained random with short periods and long dead bands
    for (int c = 0; c < 12000; c++) begin
      int r, p;
      r = $urandom_range(0, 99);
      p = $urandom_range(1, 20);
      if (r < 4) begin per_we = 1; per_d = CW'(p); end
      else if (r < 12) begin duty_we = 1; duty_d = CW'($urandom_range(0, 23)); end
      else if (r < 15) begin dt_we = 1; dt_d = DTW'($urandom_range(0, 6)); end
      else if (r < 18) begin adt_we = 1; adt_d = DTW'($urandom_range(0, 12)); end
      else if (r < 19) begin mode_we = 1; mode_d = $urandom_range(0, 1); end
      else if (r < 20) begin imm_we = 1; imm_d = $urandom_range(0, 1); end
      tick(1);
    end

    run_on = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule